// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block turns single write requests from synchronous logic into correctly ordered write cycles on the port of an external asynchronous static RAM. A request carries an address, a data word, a termination mode and an output-enable choice. The block accepts it with a valid/ready handshake and then drives the chip enable, semaphore select, read/write strobe, output enable, address lines and write data lines. Every timing value (address setup, pulse widths, bus turnaround, data setup, data hold, address hold) is a parameter counted in clock cycles.

Two ways of ending a write are offered per request. In strobe-terminated writes the enable drops first, and the read/write strobe then opens and closes the write window. The strobe's low time stretches to cover the RAM's driver turn-off plus data setup whenever the output enable is held active. In enable-terminated writes the strobe is pulled low one cycle before the enable falls, so the RAM never drives its I/O lines, and the enable pulse forms the window. Write data is placed on the lines only through a separate drive-enable output, which stays off while the RAM may still be driving.

Top module: `sram_wr_seq`

## Requirements
- R1: After reset and whenever idle, ram_ce_n, ram_rw_n, ram_oe_n and ram_sem_n are 1, ram_dq_oe is 0 and req_ready is 1.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1; ram_addr takes req_addr at that edge, req_ready is 0 from then until the write sequence ends, and ram_addr changes only at an accept edge, never while ram_rw_n is 0.
- R3: ram_sem_n is 1 in every cycle.
- R4: With req_mode 0 (strobe-terminated), ram_ce_n is 0 and ram_rw_n is 1 for the T_SA cycles that follow the accept edge.
- R5: With req_mode 1 (enable-terminated), ram_ce_n and ram_rw_n are 1 for the T_SA cycles after the accept edge; ram_rw_n then falls one cycle before ram_ce_n falls.
- R6: In mode 0 with req_oe 0, ram_rw_n is low for exactly T_PWE cycles and ram_dq_oe is 1 for all of them.
- R7: In mode 0 with req_oe 1, ram_rw_n is low for max(T_PWE, T_HZWE+T_SD) cycles and ram_dq_oe stays 0 for the first T_HZWE of them, then 1.
- R8: In mode 1, ram_ce_n is low for exactly T_SCE cycles and ram_dq_oe is 1 from the cycle ram_rw_n falls.
- R9: ram_ce_n and ram_rw_n rise on the same edge; for the following max(T_HA, T_HD) cycles ram_addr is held and ram_dq_oe stays 1 for the first T_HD of them.
- R10: ram_oe_n equals the inverse of the request's req_oe for the whole sequence and is 1 when idle.
- R11: With req_valid held at 1, the next request is accepted only once the hold phase has ended and repeats the full setup phase.
- R12: ram_dq_oe is never 1 in a cycle where ram_ce_n is 0, ram_rw_n is 1 and ram_oe_n is 0.
- R13: At the end of each write window the RAM receives ram_dq_out equal to the request's data at the request's address, driven for at least T_SD cycles before the window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| req_mode | input | 1 | 0: strobe-terminated, 1: enable-terminated |
| req_oe | input | 1 | 1: hold RAM output enable active during the write |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_sem_n | output | 1 | RAM semaphore select, held high |
| ram_rw_n | output | 1 | RAM read/write strobe, low for write |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_addr | output | AW | RAM address lines |
| ram_dq_out | output | DW | Write data toward the RAM I/O lines |
| ram_dq_oe | output | 1 | Drive enable for ram_dq_out |

## Verification
A wrong phase or counter value shows within one cycle as an enable or strobe edge at the wrong cycle, a pulse of the wrong length, or a drive-enable that overlaps the RAM's own drive, since the bench model predicts every output on every clock. A corrupt latched address or data word shows in the window at the latest, when the bench's RAM model stores a word that differs from the request. Losing track of the busy phase shows as req_ready rising early or late against the model's sequence length.

// File: rtl/sram_wr_seq.sv
module sram_wr_seq #(
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter int T_SA   = 2,
  parameter int T_PWE  = 3,
  parameter int T_SCE  = 3,
  parameter int T_HZWE = 2,
  parameter int T_SD   = 2,
  parameter int T_HD   = 1,
  parameter int T_HA   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          req_mode,
  input  logic          req_oe,
  output logic          ram_ce_n,
  output logic          ram_sem_n,
  output logic          ram_rw_n,
  output logic          ram_oe_n,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_dq_out,
  output logic          ram_dq_oe
);

  localparam int P_OE  = (T_PWE > T_HZWE + T_SD) ? T_PWE : T_HZWE + T_SD;
  localparam int P_EN  = T_SCE + 1;
  localparam int HLEN  = (T_HA > T_HD) ? T_HA : T_HD;
  localparam int MX1   = (P_OE > P_EN) ? P_OE : P_EN;
  localparam int MX2   = (T_SA > HLEN) ? T_SA : HLEN;
  localparam int MX    = (MX1 > MX2) ? MX1 : MX2;
  localparam int CW    = $clog2(MX + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_PULSE, S_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          mode_q;
  logic          oe_q;
  logic [CW-1:0] plen;
  logic [CW-1:0] turn;

  always_comb begin
    if (mode_q)    plen = CW'(P_EN);
    else if (oe_q) plen = CW'(P_OE);
    else           plen = CW'(T_PWE);
  end

  assign turn = (!mode_q && oe_q) ? CW'(T_HZWE) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      addr_q <= '0;
      data_q <= '0;
      mode_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          st     <= S_SETUP;
          cnt    <= '0;
          addr_q <= req_addr;
          data_q <= req_data;
          mode_q <= req_mode;
          oe_q   <= req_oe;
        end
        S_SETUP: if (cnt == CW'(T_SA - 1)) begin
          st  <= S_PULSE;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_PULSE: if (cnt == plen - 1'b1) begin
          st  <= S_HOLD;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_HOLD: if (cnt == CW'(HLEN - 1)) begin
          st  <= S_IDLE;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign ram_sem_n  = 1'b1;
  assign ram_rw_n   = (st != S_PULSE);
  assign ram_ce_n   = !((st == S_SETUP && !mode_q) ||
                        (st == S_PULSE && (!mode_q || cnt != '0)));
  assign ram_oe_n   = !(st != S_IDLE && oe_q);
  assign ram_addr   = addr_q;
  assign ram_dq_out = data_q;
  assign ram_dq_oe  = (st == S_PULSE && cnt >= turn) ||
                      (st == S_HOLD && cnt < CW'(T_HD));

endmodule

// File: rtl/sram_wr_seq_chk.sv
module sram_wr_seq_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          ram_ce_n,
  input logic          ram_sem_n,
  input logic          ram_rw_n,
  input logic          ram_oe_n,
  input logic [AW-1:0] ram_addr,
  input logic          ram_dq_oe
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_ce_n && ram_rw_n && ram_oe_n && !ram_dq_oe));

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_addr_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(ram_addr));

  p_addr_move_rw_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ram_addr) |-> ram_rw_n);

  p_sem_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sem_n);

  p_ce_fall_after_rw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ram_ce_n) && !ram_rw_n) |-> $past(!ram_rw_n));

  p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ram_rw_n) && !ram_ce_n && !ram_oe_n && $past(!ram_ce_n)) |-> !ram_dq_oe);

  p_end_together_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ram_ce_n) || $rose(ram_rw_n)) |-> (ram_ce_n && ram_rw_n));

  p_no_contention_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_ce_n && ram_rw_n && !ram_oe_n) |-> !ram_dq_oe);

endmodule

bind sram_wr_seq sram_wr_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .ram_ce_n(ram_ce_n), .ram_sem_n(ram_sem_n), .ram_rw_n(ram_rw_n),
  .ram_oe_n(ram_oe_n), .ram_addr(ram_addr), .ram_dq_oe(ram_dq_oe)
);

// File: tb/sim_sram_wr_seq.sv
module sim_sram_wr_seq;
  localparam int AW = 8, DW = 16;
  localparam int SA = 2, PWE = 3, SCE = 4, HZWE = 2, SD = 3, HD = 1, HA = 2;
  localparam int P_OE = (PWE > HZWE + SD) ? PWE : HZWE + SD;
  localparam int HL   = (HA > HD) ? HA : HD;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_mode = 0, req_oe = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, ram_ce_n, ram_sem_n, ram_rw_n, ram_oe_n, ram_dq_oe;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_dq_out;

  always #2 clk = ~clk;

  sram_wr_seq #(.AW(AW), .DW(DW), .T_SA(SA), .T_PWE(PWE), .T_SCE(SCE),
    .T_HZWE(HZWE), .T_SD(SD), .T_HD(HD), .T_HA(HA)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_mode(req_mode), .req_oe(req_oe),
    .ram_ce_n(ram_ce_n), .ram_sem_n(ram_sem_n), .ram_rw_n(ram_rw_n),
    .ram_oe_n(ram_oe_n), .ram_addr(ram_addr), .ram_dq_out(ram_dq_out),
    .ram_dq_oe(ram_dq_oe));

  int total = 0, bad = 0;
  bit done = 0, live = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  int busy = 0, t = 0, m_mode = 0, m_oe = 0, plen = 0, cyc = 0, last_acc = -1, last_len = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      busy = 0; t = 0; m_addr = '0; m_data = '0;
    end else if (busy) begin
      t++;
      if (t == SA + plen + HL) busy = 0;
    end else if (req_valid) begin
      if (last_acc >= 0) chk(cyc - last_acc >= last_len, "R11", cyc - last_acc, last_len);
      busy = 1; t = 0;
      m_addr = req_addr; m_data = req_data; m_mode = req_mode; m_oe = req_oe;
      plen = m_mode ? SCE + 1 : (m_oe ? P_OE : PWE);
      last_acc = cyc; last_len = SA + plen + HL + 1;
    end
  end

  always @(negedge clk) if (rst_n && live) begin
    int e_ce, e_rw, e_dq, u;
    string tg;
    e_ce = 1; e_rw = 1; e_dq = 0; tg = "R1";
    if (busy) begin
      if (t < SA) begin
        e_ce = m_mode ? 1 : 0; tg = m_mode ? "R5" : "R4";
      end else if (t < SA + plen) begin
        u = t - SA; e_rw = 0;
        e_ce = (m_mode && u == 0) ? 1 : 0;
        e_dq = (!m_mode && m_oe) ? (u >= HZWE) : 1;
        tg = m_mode ? "R8" : (m_oe ? "R7" : "R6");
      end else begin
        e_dq = (t - SA - plen) < HD; tg = "R9";
      end
    end
    chk(req_ready == !busy, "R2", req_ready, !busy);
    chk(ram_ce_n == e_ce, tg, ram_ce_n, e_ce);
    chk(ram_rw_n == e_rw, tg, ram_rw_n, e_rw);
    chk(ram_dq_oe == e_dq, tg, ram_dq_oe, e_dq);
    chk(ram_sem_n == 1, "R3", ram_sem_n, 1);
    chk(ram_oe_n == (busy ? !m_oe : 1), "R10", ram_oe_n, busy ? !m_oe : 1);
    chk(ram_addr == m_addr, "R2", ram_addr, m_addr);
    if (ram_dq_oe) chk(ram_dq_out == m_data, "R13", ram_dq_out, m_data);
    chk(!(!ram_ce_n && ram_rw_n && !ram_oe_n && ram_dq_oe), "R12", ram_dq_oe, 0);
  end

  // behavioural RAM
  logic [DW-1:0] mem [int];
  logic [DW-1:0] exp_mem [int];
  bit inwin = 0;
  int drv = 0;
  logic [AW-1:0] waddr = '0;
  logic [DW-1:0] wdat = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      inwin = 0; drv = 0;
    end else if (!ram_ce_n && !ram_rw_n && ram_sem_n) begin
      if (!inwin) begin inwin = 1; waddr = ram_addr; drv = 0; end
      if (ram_addr != waddr) chk(0, "R2", ram_addr, waddr);
      if (ram_dq_oe) begin drv++; wdat = ram_dq_out; end else drv = 0;
    end else if (inwin) begin
      inwin = 0;
      chk(drv >= SD, "R13", drv, SD);
      mem[int'(waddr)] = wdat;
    end
  end

  task automatic send(input int a, input int d, input bit m, input bit o, input bit rec);
    @(negedge clk);
    req_valid = 1; req_addr = AW'(a); req_data = DW'(d); req_mode = m; req_oe = o;
    forever begin
      if (req_ready) begin @(posedge clk); break; end
      @(negedge clk);
    end
    if (rec) exp_mem[a] = DW'(d);
  endtask

  task automatic pause(input int n);
    @(negedge clk); req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ram_ce_n && ram_rw_n && ram_oe_n && ram_sem_n && !ram_dq_oe, "R1",
        {ram_ce_n, ram_rw_n, ram_oe_n, ram_sem_n, ram_dq_oe}, 5'b11110);
    chk(req_ready == 1, "R1", req_ready, 1);
    rst_n = 1; live = 1;
    pause(3);
    send(8'h10, 16'hA5A5, 0, 0, 1);
    pause(4);
    send(8'h11, 16'h5A5A, 0, 1, 1);
    pause(2);
    send(8'h12, 16'h1234, 1, 0, 1);
    send(8'h13, 16'hFEDC, 1, 1, 1);
    send(8'h14, 16'h0F0F, 0, 1, 1);
    send(8'h15, 16'hF0F0, 0, 0, 1);
    pause(6);
    for (int i = 0; i < 24; i++) begin
      send((i * 37) & 8'hFF, (i * 16'h1357) ^ 16'hC3C3, i[0], i[1], 1);
      if (i % 5 == 4) pause(i % 3);
    end
    send(8'h10, 16'h7777, 1, 1, 1);
    send(8'h10, 16'h8888, 0, 1, 1);
    pause(3);
    send(8'hEE, 16'hDEAD, 0, 1, 0);
    repeat (SA + 2) @(posedge clk);
    #1 rst_n = 0; req_valid = 0;
    @(negedge clk);
    chk(ram_ce_n && ram_rw_n && ram_oe_n && !ram_dq_oe && req_ready, "R1",
        {ram_ce_n, ram_rw_n, ram_oe_n, ram_dq_oe, req_ready}, 5'b11101);
    @(posedge clk); #1 rst_n = 1;
    last_acc = -1;
    pause(2);
    send(8'h20, 16'h2468, 0, 1, 1);
    pause(SA + P_OE + HL + 4);
    chk(!mem.exists(8'hEE), "R13", mem.exists(8'hEE), 0);
    foreach (exp_mem[k])
      chk(mem.exists(k) && mem[k] == exp_mem[k], "R13", mem.exists(k) ? int'(mem[k]) : -1, exp_mem[k]);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule